// File: doc/BRIEF.md
# Two-Wide Static Packet Issue Front End

This block sits between an aligned instruction fetch port and the two execution lanes of an in-order, statically scheduled processor. Each cycle it presents a packet address to the fetch port and receives back one 64-bit packet holding two 32-bit instruction words. The word at the lower address goes to the ALU/branch lane. The word at the higher address goes to the load/store lane. Each lane receives its own valid flag, instruction word and PC. The compiler is trusted to have removed every dependence hazard, so both words issue in the same cycle and no hazard logic exists.

The block checks that each word belongs to the class its slot allows. It also checks that a branch target keeps packets aligned. An all-zero word is a filler nop and leaves its lane idle. A branch in the ALU slot steers the next fetch. Otherwise the packet address steps by one packet. A single ready input from downstream freezes the whole block. Reset loads an aligned start address.

Top module: `dual_issue_front`

## Requirements
- R1: In the cycle after a synchronous reset, `fetch_addr_o` equals `RESET_VEC` with its low three bits cleared, and both lane valids, `illegal_o` and `misalign_o` are 0.
- R2: On a clock edge with `issue_ready_i` high, the outputs take the packet fetched from address P. `alu_insn_o` takes bits 31:0 of the packet and `mem_insn_o` takes bits 63:32 (both are loaded even when their lane is invalid). `alu_pc_o` takes P and `mem_pc_o` takes P+4.
- R3: When a packet is accepted and it does not redirect, the next `fetch_addr_o` is P+8.
- R4: The class of a word is bits 31:30: 00 ALU, 01 branch, 10 load/store, 11 reserved. A branch always redirects. Its target is P plus bits 15:0 of the word, sign-extended, as a byte offset.
- R5: An all-zero word is a nop. Its lane valid is 0 and the other lane is unaffected.
- R6: A packet is illegal in either of two cases. The first is a nonzero ALU-slot word of class 10 or 11. The second is a nonzero load/store-slot word of a class other than 10. For an illegal packet, `illegal_o` is 1, both valids are 0, no redirect occurs, and the address steps by 8.
- R7: A legal packet with a branch in the ALU slot and an aligned target issues normally, and the next `fetch_addr_o` is the target.
- R8: A legal packet whose branch target has any of bits 2:0 set raises `misalign_o`. Both of its valids are 0 and the address steps by 8 instead. `misalign_o` and `illegal_o` are never both 1.
- R9: While `issue_ready_i` is low at an edge, `fetch_addr_o` and every lane and flag output keep their values.
- R10: Bits 2:0 of `fetch_addr_o` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr_o | output | 32 | Address of the packet being fetched |
| fetch_pkt_i | input | 64 | Packet at `fetch_addr_o`, returned in the same cycle |
| issue_ready_i | input | 1 | Downstream accepts a packet this cycle |
| alu_valid_o | output | 1 | ALU/branch lane holds a real instruction |
| alu_insn_o | output | 32 | ALU/branch lane instruction word |
| alu_pc_o | output | 32 | ALU/branch lane PC |
| mem_valid_o | output | 1 | Load/store lane holds a real instruction |
| mem_insn_o | output | 32 | Load/store lane instruction word |
| mem_pc_o | output | 32 | Load/store lane PC |
| illegal_o | output | 1 | Issued packet broke a slot-class rule |
| misalign_o | output | 1 | Issued packet's branch target was misaligned |

## Verification
A corrupt packet address shows up at `fetch_addr_o` on the very next cycle. One cycle later it shows up as a wrong lane PC. A corrupt lane or flag register is visible at the lane outputs as soon as the packet it belongs to is issued. A bad stall path also shows within one cycle, as a changed output while ready is low. The bench keeps an independent per-cycle model of the address sequence, the lanes and the flags. It compares that model with the ports after every edge, including the edges where ready is low.

// File: rtl/di_pkg.sv
package di_pkg;

    // Instruction class held in the two top bits of a word
    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_BR  = 2'b01,
        CLS_MEM = 2'b10,
        CLS_RSV = 2'b11
    } slot_cls_e;

    localparam int unsigned CLS_W = 2;

    // Slot roles, chosen by position inside a packet
    localparam int unsigned ROLE_ALU = 0;
    localparam int unsigned ROLE_MEM = 1;

endpackage

// File: rtl/di_slot_dec.sv
module di_slot_dec
    import di_pkg::*;
#(
    parameter int unsigned INSN_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned ROLE   = 0
) (
    input  logic [INSN_W-1:0] insn_i,
    output logic              is_nop_o,
    output logic              legal_o,
    output logic              is_branch_o,
    output logic [OFF_W-1:0]  offset_o
);

    slot_cls_e cls;

    always_comb begin
        cls         = slot_cls_e'(insn_i[INSN_W-1 -: CLS_W]);
        is_nop_o    = (insn_i == '0);
        is_branch_o = !is_nop_o && (cls == CLS_BR);
        offset_o    = insn_i[OFF_W-1:0];
    end

    // Legality depends on the slot position
    generate
        if (ROLE == ROLE_ALU) begin : g_alu_role
            always_comb begin
                legal_o = is_nop_o || (cls == CLS_ALU) || (cls == CLS_BR);
            end
        end else begin : g_mem_role
            always_comb begin
                legal_o = is_nop_o || (cls == CLS_MEM);
            end
        end
    endgenerate

endmodule

// File: rtl/di_pc_next.sv
module di_pc_next #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned PKT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              br_req_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic              misalign_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    localparam int unsigned ALIGN_BITS = $clog2(PKT_BYTES);

    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_pc;

    always_comb begin
        target     = pc_i + {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
        seq_pc     = pc_i + ADDR_W'(PKT_BYTES);
        misalign_o = br_req_i && (target[ALIGN_BITS-1:0] != '0);
        redirect_o = br_req_i && !misalign_o;
        next_pc_o  = redirect_o ? target : seq_pc;
    end

endmodule

// File: rtl/dual_issue_front.sv
module dual_issue_front
    import di_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned INSN_W    = 32,
    parameter int unsigned OFF_W     = 16,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [ADDR_W-1:0]     fetch_addr_o,
    input  logic [2*INSN_W-1:0]   fetch_pkt_i,
    input  logic                  issue_ready_i,
    output logic                  alu_valid_o,
    output logic [INSN_W-1:0]     alu_insn_o,
    output logic [ADDR_W-1:0]     alu_pc_o,
    output logic                  mem_valid_o,
    output logic [INSN_W-1:0]     mem_insn_o,
    output logic [ADDR_W-1:0]     mem_pc_o,
    output logic                  illegal_o,
    output logic                  misalign_o
);

    localparam int unsigned SLOTS      = 2;
    localparam int unsigned SLOT_BYTES = INSN_W / 8;
    localparam int unsigned PKT_BYTES  = SLOTS * SLOT_BYTES;
    localparam int unsigned ALIGN_BITS = $clog2(PKT_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(PKT_BYTES - 1);
    localparam logic [ADDR_W-1:0] RESET_PC   = ADDR_W'(RESET_VEC) & ~ALIGN_MASK;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              alu_v;
        logic [INSN_W-1:0] alu_insn;
        logic [ADDR_W-1:0] alu_pc;
        logic              mem_v;
        logic [INSN_W-1:0] mem_insn;
        logic [ADDR_W-1:0] mem_pc;
        logic              illegal;
        logic              misalign;
    } front_st_t;

    localparam front_st_t RESET_ST = '{
        pc:       RESET_PC,
        alu_v:    1'b0,
        alu_insn: '0,
        alu_pc:   '0,
        mem_v:    1'b0,
        mem_insn: '0,
        mem_pc:   '0,
        illegal:  1'b0,
        misalign: 1'b0
    };

    front_st_t st_d, st_q;

    // Per-slot decode
    logic [INSN_W-1:0] slot_word [SLOTS];
    logic [SLOTS-1:0]  slot_nop;
    logic [SLOTS-1:0]  slot_legal;
    logic [SLOTS-1:0]  slot_branch;
    logic [OFF_W-1:0]  slot_off [SLOTS];

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign slot_word[s] = fetch_pkt_i[s*INSN_W +: INSN_W];
            di_slot_dec #(
                .INSN_W (INSN_W),
                .OFF_W  (OFF_W),
                .ROLE   (s)
            ) u_dec (
                .insn_i      (slot_word[s]),
                .is_nop_o    (slot_nop[s]),
                .legal_o     (slot_legal[s]),
                .is_branch_o (slot_branch[s]),
                .offset_o    (slot_off[s])
            );
        end
    endgenerate

    logic              pkt_illegal;
    logic              br_req;
    logic              br_misalign;
    logic              br_redirect;
    logic [ADDR_W-1:0] pc_next;

    assign pkt_illegal = !(&slot_legal);
    assign br_req      = !pkt_illegal && slot_branch[ROLE_ALU];

    di_pc_next #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .PKT_BYTES (PKT_BYTES)
    ) u_pc_next (
        .pc_i       (st_q.pc),
        .br_req_i   (br_req),
        .offset_i   (slot_off[ROLE_ALU]),
        .misalign_o (br_misalign),
        .redirect_o (br_redirect),
        .next_pc_o  (pc_next)
    );

    // Next-state computation
    always_comb begin
        logic issue_ok;
        st_d     = st_q;
        issue_ok = !pkt_illegal && !br_misalign;
        if (issue_ready_i) begin
            st_d.pc       = pc_next;
            st_d.alu_insn = slot_word[ROLE_ALU];
            st_d.mem_insn = slot_word[ROLE_MEM];
            st_d.alu_pc   = st_q.pc;
            st_d.mem_pc   = st_q.pc + ADDR_W'(SLOT_BYTES);
            st_d.alu_v    = issue_ok && !slot_nop[ROLE_ALU];
            st_d.mem_v    = issue_ok && !slot_nop[ROLE_MEM];
            st_d.illegal  = pkt_illegal;
            st_d.misalign = br_misalign;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr_o = st_q.pc;
    assign alu_valid_o  = st_q.alu_v;
    assign alu_insn_o   = st_q.alu_insn;
    assign alu_pc_o     = st_q.alu_pc;
    assign mem_valid_o  = st_q.mem_v;
    assign mem_insn_o   = st_q.mem_insn;
    assign mem_pc_o     = st_q.mem_pc;
    assign illegal_o    = st_q.illegal;
    assign misalign_o   = st_q.misalign;

    // Assertions

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!alu_valid_o && !mem_valid_o && !illegal_o && !misalign_o
                        && fetch_addr_o == RESET_PC));

    p_lane_pc_pair_r2: assert property (@(posedge clk) disable iff (rst)
        (alu_valid_o || mem_valid_o) |-> (mem_pc_o == alu_pc_o + ADDR_W'(SLOT_BYTES)));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (issue_ready_i && !br_redirect) |=> (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(PKT_BYTES)));

    p_nop_idle_alu_r5: assert property (@(posedge clk) disable iff (rst)
        alu_valid_o |-> (alu_insn_o != '0));

    p_nop_idle_mem_r5: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o |-> (mem_insn_o != '0));

    p_illegal_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!alu_valid_o && !mem_valid_o));

    p_misalign_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (!alu_valid_o && !mem_valid_o && !illegal_o));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !issue_ready_i |=> ($stable(fetch_addr_o) && $stable(alu_valid_o) && $stable(mem_valid_o)
                            && $stable(alu_insn_o) && $stable(mem_insn_o)
                            && $stable(illegal_o) && $stable(misalign_o)));

    p_fetch_aligned_r10: assert property (@(posedge clk) disable iff (rst)
        fetch_addr_o[ALIGN_BITS-1:0] == '0);

endmodule

// File: tb/dual_issue_front_bench.sv
module dual_issue_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RV = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready = 1'b1;
    logic [31:0] fetch_addr;
    logic [63:0] fetch_pkt;
    logic        alu_valid, mem_valid, illegal, misalign;
    logic [31:0] alu_insn, alu_pc, mem_insn, mem_pc;

    logic [63:0] prog [32];

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fetch_pkt = prog[fetch_addr[7:3]];

    dual_issue_front #(.RESET_VEC(RV)) u_dual_issue_front (
        .clk           (clk),
        .rst           (rst),
        .fetch_addr_o  (fetch_addr),
        .fetch_pkt_i   (fetch_pkt),
        .issue_ready_i (ready),
        .alu_valid_o   (alu_valid),
        .alu_insn_o    (alu_insn),
        .alu_pc_o      (alu_pc),
        .mem_valid_o   (mem_valid),
        .mem_insn_o    (mem_insn),
        .mem_pc_o      (mem_pc),
        .illegal_o     (illegal),
        .misalign_o    (misalign)
    );

    // Behavioural reference model
    logic [31:0] m_pc = RV;
    logic        m_av = 1'b0, m_mv = 1'b0, m_ill = 1'b0, m_mis = 1'b0;
    logic [31:0] m_ai = '0, m_mi = '0, m_apc = '0, m_mpc = '0;

    always @(posedge clk) begin
        logic [63:0] p;
        logic [31:0] a, m, tgt;
        logic        ill, jmp, mis;
        if (rst) begin
            m_pc = RV; m_av = 0; m_mv = 0; m_ill = 0; m_mis = 0;
            m_ai = 0; m_mi = 0; m_apc = 0; m_mpc = 0;
        end else if (ready) begin
            p   = prog[m_pc[7:3]];
            a   = p[31:0];
            m   = p[63:32];
            ill = (a != 0 && a[31]) || (m != 0 && m[31:30] != 2'b10);
            jmp = !ill && a[31:30] == 2'b01;
            tgt = m_pc + {{16{a[15]}}, a[15:0]};
            mis = jmp && tgt[2:0] != 0;
            m_ai = a; m_mi = m; m_apc = m_pc; m_mpc = m_pc + 4;
            m_av = !ill && !mis && a != 0;
            m_mv = !ill && !mis && m != 0;
            m_ill = ill; m_mis = mis;
            m_pc = (jmp && !mis) ? tgt : m_pc + 8;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk("R3/R7 fetch_addr", fetch_addr, m_pc);
        chk("R10 fetch alignment", {29'd0, fetch_addr[2:0]}, 32'd0);
        chk("R5 alu_valid", {31'd0, alu_valid}, {31'd0, m_av});
        chk("R5 mem_valid", {31'd0, mem_valid}, {31'd0, m_mv});
        chk("R2 alu_insn", alu_insn, m_ai);
        chk("R2 mem_insn", mem_insn, m_mi);
        chk("R2 alu_pc", alu_pc, m_apc);
        chk("R2 mem_pc", mem_pc, m_mpc);
        chk("R6 illegal", {31'd0, illegal}, {31'd0, m_ill});
        chk("R8 misalign", {31'd0, misalign}, {31'd0, m_mis});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        chk("R1 reset fetch_addr", fetch_addr, RV);
        chk("R1 reset valids", {30'd0, alu_valid, mem_valid}, 32'd0);
        chk("R1 reset flags", {30'd0, illegal, misalign}, 32'd0);
    endtask

    function automatic logic [63:0] mk(input int i, input int v);
        logic [31:0] aw, mw;
        aw = 32'h0000_1000 | 32'(i);
        mw = 32'h8000_2000 | 32'(i);
        case ((i * 3 + v) % 10)
            0: return {mw, aw};
            1: return {mw, 32'h0};
            2: return {32'h0, aw};
            3: return 64'h0;
            4: return {mw, 32'h4000_0018};
            5: return {mw, 32'h4000_FFD8};
            6: return {mw, 32'h4000_0004};
            7: return {mw, 32'h8000_0010};
            8: return {32'h0000_0020, aw};
            default: return {32'hC000_0001, aw};
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] h_addr, h_ai;
        logic        h_av;
        for (int i = 0; i < 32; i++) prog[i] = mk(i, 0);
        @(negedge clk);

        // Directed: branch in first packet (R4, R7)
        prog[0] = {32'h8000_0005, 32'h4000_0018};
        do_reset();
        ready = 1'b1;
        step();
        chk("R4 branch target", fetch_addr, RV + 32'h18);
        chk("R7 branch packet issues", {30'd0, alu_valid, mem_valid}, 32'd3);
        chk("R2 branch word on alu lane", alu_insn, 32'h4000_0018);

        // Directed: stall holds everything (R9)
        h_addr = fetch_addr; h_ai = alu_insn; h_av = alu_valid;
        ready = 1'b0;
        for (int k = 0; k < 3; k++) step();
        chk("R9 stalled fetch_addr", fetch_addr, h_addr);
        chk("R9 stalled alu_insn", alu_insn, h_ai);
        chk("R9 stalled alu_valid", {31'd0, alu_valid}, {31'd0, h_av});
        ready = 1'b1;

        // Directed: misaligned target (R8)
        prog[0] = {32'h8000_0005, 32'h4000_0004};
        do_reset();
        step();
        chk("R8 misalign raised", {31'd0, misalign}, 32'd1);
        chk("R8 no redirect", fetch_addr, RV + 32'h8);

        // Directed: ALU slot holding a load/store word (R6)
        prog[0] = {32'h8000_0005, 32'h8000_0006};
        do_reset();
        step();
        chk("R6 illegal raised", {31'd0, illegal}, 32'd1);
        chk("R6 lanes idle", {30'd0, alu_valid, mem_valid}, 32'd0);

        // Model-compared runs over several program images and ready patterns
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 32; i++) prog[i] = mk(i, v);
            do_reset();
            for (int c = 0; c < 150; c++) begin
                ready = (v % 2 == 0) ? 1'b1 : (($urandom % 4) != 0);
                step();
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule